// File: doc/BRIEF.md
# Strobed Handshake Port Pair

This block gives a processor two parallel data ports, A and B, that exchange bytes with a peripheral through a strobed handshake. Each port is set on its own as a latched input or a latched output. In input mode a low strobe from the peripheral captures the port pins into a latch and raises an input-full flag. In output mode a processor write places a byte on the pins and asserts an active-low output-full flag, which the peripheral clears with an acknowledge pulse. Each port has an interrupt request gated by its own enable flip-flop.

The processor side is a synchronous bus: active-low select, read and write strobes, a 2-bit address and separate data-in and data-out buses. A write or read takes effect on the first clock where the strobe is low with the select low. The handshake lines of both ports share an 8-bit control/status port whose pin assignment follows the direction chosen for each port. Handshake inputs from the peripheral pass through a configurable synchronizer before use.

Top module: `strobed_port_pair`

## Requirements
- R1: After reset both ports are inputs, all full flags are inactive (input-full low, output-full high), both interrupt enables and interrupt requests are 0, the free status outputs are 0, and the status pins drive 0x00 with output enables 0xEB.
- R2: With a port in input mode, while its synchronized strobe is low the port pins are loaded into the latch every clock and input-full goes high; a read at address 0 (port A) or 1 (port B) returns the latch, which holds its value after the strobe returns high.
- R3: An input port's interrupt request is high exactly when input-full is high, the synchronized strobe is high and the enable is set; a read of the port clears input-full and so the request.
- R4: With a port in output mode, a write to its address drives the written byte on its pins, drives output-full low and clears its interrupt request.
- R5: In output mode a falling synchronized acknowledge sets output-full high again, and a rising synchronized acknowledge sets the interrupt request if the port's enable is set; with the enable clear the request stays low.
- R6: Status pin map: port A input uses bit 4 strobe, bit 5 input-full, bit 3 request, free bits 6 and 7; port A output uses bit 6 acknowledge, bit 7 output-full, bit 3 request, free bits 4 and 5; port B uses bit 2 strobe/acknowledge, bit 1 full flag, bit 0 request. Output enables are low only on the handshake input pins.
- R7: A control write (address 3) with bit 7 set and bits 6..2 zero selects directions (bit 0 = 1: port A input, bit 1 = 1: port B input) and clears all flags, requests, enables and free outputs; with any of bits 6..2 set the word is ignored.
- R8: A control write with bit 7 clear and bits 6..4 zero writes bit 0 into the status bit indexed by bits 3..1: the index of a port's handshake input pin writes that port's enable, the index of a free pin writes that output, any other index is ignored.
- R9: A read at address 2 returns the status pins as seen on their inputs, except that each handshake input position shows that port's interrupt enable.
- R10: A write to the data address of a port in input mode leaves its latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0 port A, 1 port B, 2 status, 3 control |
| cpu_din | input | DATA_W | Write data |
| cpu_dout | output | DATA_W | Read data, zero when not reading |
| pa_in | input | DATA_W | Port A pins in |
| pa_out | output | DATA_W | Port A pins out |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | DATA_W | Port B pins in |
| pb_out | output | DATA_W | Port B pins out |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Status port pins in |
| pc_out | output | 8 | Status port pins out |
| pc_oe | output | 8 | Status port drive enables |

## Verification
With the default two synchronizer stages, an input-full flag rises three clocks after the strobe pin falls, an input-port request rises two clocks after the strobe returns high, and output-full and the output-port request change three clocks after the acknowledge pin edge. Register updates from a processor write or read appear one clock after the strobe falls, while read data is combinational during the strobe. The bench queues each expected value with the cycle it is due, checks it one nanosecond after the falling clock edge of that cycle, and also checks the cycle before a handshake result to catch one that comes early.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   localparam logic [1:0] ADR_PA  = 2'd0;
   localparam logic [1:0] ADR_PB  = 2'd1;
   localparam logic [1:0] ADR_ST  = 2'd2;
   localparam logic [1:0] ADR_CTL = 2'd3;

   // status port bit positions
   localparam int B_REQ   = 0;
   localparam int B_FULL  = 1;
   localparam int B_HS    = 2;
   localparam int A_REQ   = 3;
   localparam int A_STB   = 4;
   localparam int A_IBF   = 5;
   localparam int A_ACK   = 6;
   localparam int A_OBF   = 7;

   localparam int HS_PINS = 3;

   typedef struct packed {
      logic a_in;
      logic b_in;
   } dir_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_in,
   input  logic          clr,
   input  logic          hs_n,
   input  logic          rd_evt,
   input  logic          wr_evt,
   input  logic          inte,
   input  logic [DW-1:0] pin_d,
   input  logic [DW-1:0] cpu_d,
   output logic [DW-1:0] data_q,
   output logic          ibf,
   output logic          obf_n,
   output logic          intr
);
   logic hs_prev;
   logic oreq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         ibf     <= 1'b0;
         obf_n   <= 1'b1;
         oreq    <= 1'b0;
         hs_prev <= 1'b1;
      end else begin
         hs_prev <= hs_n;
         if (clr) begin
            ibf   <= 1'b0;
            obf_n <= 1'b1;
            oreq  <= 1'b0;
         end else if (is_in) begin
            if (!hs_n) begin
               data_q <= pin_d;
               ibf    <= 1'b1;
            end else if (rd_evt) begin
               ibf <= 1'b0;
            end
         end else begin
            if (wr_evt) begin
               data_q <= cpu_d;
               obf_n  <= 1'b0;
               oreq   <= 1'b0;
            end else begin
               if (hs_prev && !hs_n)         obf_n <= 1'b1;
               if (!hs_prev && hs_n && inte) oreq  <= 1'b1;
            end
         end
      end
   end

   assign intr = is_in ? (ibf && hs_n && inte) : oreq;

   AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in && !clr && !hs_n) |=> ibf);                                   // R2
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in && !clr && hs_n && rd_evt) |=> !ibf);                         // R3
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_in && !clr && wr_evt) |=> (!obf_n && !intr));                   // R4
   AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_in && !clr && !wr_evt && hs_prev && !hs_n) |=> obf_n);          // R5
   AST_IBF_ONLY_IN: assert property (@(posedge clk) disable iff (!rst_n)
      !is_in |-> !ibf);                                                    // R7
   AST_OBF_ONLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      is_in |-> obf_n);                                                    // R7
endmodule

// File: rtl/hsp_ctl.sv
module hsp_ctl
   import hsp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] din,
   output logic          rd_a,
   output logic          rd_b,
   output logic          wr_a,
   output logic          wr_b,
   output logic          clr,
   output dir_t          dir,
   output logic          inte_a,
   output logic          inte_b,
   output logic [1:0]    free_q
);
   logic wr_prev, rd_prev;
   logic wr_evt, rd_evt, ctl_wr, bsr_ok, rsv_mode;
   logic [2:0] idx;
   logic [2:0] a_hs_idx, free_lo, free_hi;

   assign wr_evt   = !cs_n && !wr_n && wr_prev;
   assign rd_evt   = !cs_n && !rd_n && rd_prev;
   assign ctl_wr   = wr_evt && (addr == ADR_CTL);
   assign clr      = ctl_wr && din[7] && (din[6:2] == 5'd0);
   assign rsv_mode = ctl_wr && din[7] && (din[6:2] != 5'd0);
   assign bsr_ok   = ctl_wr && !din[7] && (din[6:4] == 3'd0);
   assign wr_a     = wr_evt && (addr == ADR_PA);
   assign wr_b     = wr_evt && (addr == ADR_PB);
   assign rd_a     = rd_evt && (addr == ADR_PA);
   assign rd_b     = rd_evt && (addr == ADR_PB);

   assign idx      = din[3:1];
   assign a_hs_idx = dir.a_in ? 3'(A_STB) : 3'(A_ACK);
   assign free_lo  = dir.a_in ? 3'(A_ACK) : 3'(A_STB);
   assign free_hi  = dir.a_in ? 3'(A_OBF) : 3'(A_IBF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
         rd_prev <= 1'b1;
         dir     <= '{a_in: 1'b1, b_in: 1'b1};
         inte_a  <= 1'b0;
         inte_b  <= 1'b0;
         free_q  <= 2'b00;
      end else begin
         wr_prev <= wr_n;
         rd_prev <= rd_n;
         if (clr) begin
            dir.a_in <= din[0];
            dir.b_in <= din[1];
            inte_a   <= 1'b0;
            inte_b   <= 1'b0;
            free_q   <= 2'b00;
         end else if (bsr_ok) begin
            if (idx == a_hs_idx)  inte_a    <= din[0];
            if (idx == 3'(B_HS))  inte_b    <= din[0];
            if (idx == free_lo)   free_q[0] <= din[0];
            if (idx == free_hi)   free_q[1] <= din[0];
         end
      end
   end

   AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!inte_a && !inte_b && free_q == 2'b00));                    // R7
   AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_mode |=> $stable(dir));                                          // R7
endmodule

// File: rtl/strobed_port_pair.sv
module strobed_port_pair
   import hsp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] cpu_din,
   output logic [DATA_W-1:0] cpu_dout,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic              pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic              pb_oe,
   input  logic [7:0]        pc_in,
   output logic [7:0]        pc_out,
   output logic [7:0]        pc_oe
);
   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic rd_a, rd_b, wr_a, wr_b, clr, inte_a, inte_b;
   dir_t dir;
   logic [1:0] free_q;
   logic [HS_PINS-1:0] hs_raw, hs_s;
   logic hs_a, hs_b;
   logic ibf_a, obf_n_a, intr_a, ibf_b, obf_n_b, intr_b;
   logic [DATA_W-1:0] data_a, data_b;
   logic [7:0] st_rd;

   hsp_ctl #(.DW(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(cpu_din), .rd_a(rd_a), .rd_b(rd_b), .wr_a(wr_a),
      .wr_b(wr_b), .clr(clr), .dir(dir), .inte_a(inte_a), .inte_b(inte_b),
      .free_q(free_q)
   );

   assign hs_raw = {pc_in[A_ACK], pc_in[A_STB], pc_in[B_HS]};

   genvar g;
   generate
      for (g = 0; g < HS_PINS; g++) begin : g_sync
         hsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(hs_raw[g]), .q(hs_s[g])
         );
      end
   endgenerate

   assign hs_b = hs_s[0];
   assign hs_a = dir.a_in ? hs_s[1] : hs_s[2];

   hsp_port #(.DW(DATA_W)) u_port_a (
      .clk(clk), .rst_n(rst_n), .is_in(dir.a_in), .clr(clr), .hs_n(hs_a),
      .rd_evt(rd_a), .wr_evt(wr_a), .inte(inte_a), .pin_d(pa_in),
      .cpu_d(cpu_din), .data_q(data_a), .ibf(ibf_a), .obf_n(obf_n_a),
      .intr(intr_a)
   );

   hsp_port #(.DW(DATA_W)) u_port_b (
      .clk(clk), .rst_n(rst_n), .is_in(dir.b_in), .clr(clr), .hs_n(hs_b),
      .rd_evt(rd_b), .wr_evt(wr_b), .inte(inte_b), .pin_d(pb_in),
      .cpu_d(cpu_din), .data_q(data_b), .ibf(ibf_b), .obf_n(obf_n_b),
      .intr(intr_b)
   );

   always_comb begin
      pc_out         = '0;
      pc_out[B_REQ]  = intr_b;
      pc_out[B_FULL] = dir.b_in ? ibf_b : obf_n_b;
      pc_out[A_REQ]  = intr_a;
      if (dir.a_in) begin
         pc_out[A_IBF] = ibf_a;
         pc_out[A_ACK] = free_q[0];
         pc_out[A_OBF] = free_q[1];
      end else begin
         pc_out[A_OBF] = obf_n_a;
         pc_out[A_STB] = free_q[0];
         pc_out[A_IBF] = free_q[1];
      end
      pc_oe       = '1;
      pc_oe[B_HS] = 1'b0;
      if (dir.a_in) pc_oe[A_STB] = 1'b0;
      else          pc_oe[A_ACK] = 1'b0;
   end

   always_comb begin
      st_rd       = pc_in;
      st_rd[B_HS] = inte_b;
      if (dir.a_in) st_rd[A_STB] = inte_a;
      else          st_rd[A_ACK] = inte_a;
   end

   always_comb begin
      cpu_dout = '0;
      if (!cs_n && !rd_n) begin
         case (addr)
            ADR_PA:  cpu_dout = data_a;
            ADR_PB:  cpu_dout = data_b;
            ADR_ST:  cpu_dout = DATA_W'(st_rd);
            default: cpu_dout = '0;
         endcase
      end
   end

   assign pa_out = data_a;
   assign pb_out = data_b;
   assign pa_oe  = !dir.a_in;
   assign pb_oe  = !dir.b_in;

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pa_oe == !$past(cpu_din[0]) && pb_oe == !$past(cpu_din[1]))); // R6
endmodule

// File: tb/tb_strobed_port_pair.sv
`timescale 1ns/1ps
module tb_strobed_port_pair;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] cpu_din = 8'h00;
   logic [7:0] cpu_dout;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
   logic [7:0] pa_out, pb_out;
   logic pa_oe, pb_oe;
   logic [7:0] drv_c = 8'hFF;
   logic [7:0] pc_in, pc_out, pc_oe;

   int cyc = 0;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      int         due;
      int         sel;
      logic [7:0] mask;
      logic [7:0] exp;
      string      req;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign pc_in = (pc_out & pc_oe) | (drv_c & ~pc_oe);

   strobed_port_pair #(.DATA_W(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   // sel: 0 pc_out, 1 pa_out, 2 pb_out, 3 cpu_dout, 4 pc_oe, 5 {pa_oe,pb_oe}
   function automatic logic [7:0] observe(int sel);
      case (sel)
         0: return pc_out;
         1: return pa_out;
         2: return pb_out;
         3: return cpu_dout;
         4: return pc_oe;
         default: return {6'd0, pa_oe, pb_oe};
      endcase
   endfunction

   task automatic expect_at(int sel, logic [7:0] mask, logic [7:0] exp, string req, int dly);
      item_t it;
      it.due = cyc + dly; it.sel = sel; it.mask = mask; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   // monitor: compares due items one ns after each falling edge
   always @(negedge clk) begin
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            logic [7:0] act;
            act = observe(sb[i].sel) & sb[i].mask;
            checks++;
            if (act !== sb[i].exp) begin
               errors++;
               $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                        sb[i].req, sb[i].sel, cyc, act, sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; cpu_din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic cpu_rd(logic [1:0] a, logic [7:0] exp, string req);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      expect_at(3, 8'hFF, exp, req, 0);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      expect_at(0, 8'hFF, 8'h00, "R1", 0);
      expect_at(4, 8'hFF, 8'hEB, "R1", 0);
      expect_at(5, 8'hFF, 8'h00, "R1", 0);
      tick(1);
      cpu_rd(2'd2, 8'h00, "R1");

      // R8 enable port A (index 4 while input), R9 readback
      cpu_wr(2'd3, 8'h09);
      cpu_rd(2'd2, 8'h10, "R9");

      // R2/R3 port A strobe
      pa_in = 8'hA5;
      drv_c[4] = 1'b0;
      expect_at(0, 8'h20, 8'h00, "R2", 2);
      expect_at(0, 8'h20, 8'h20, "R2", 3);
      expect_at(0, 8'h08, 8'h00, "R3", 3);
      tick(4);
      drv_c[4] = 1'b1;
      expect_at(0, 8'h08, 8'h00, "R3", 1);
      expect_at(0, 8'h08, 8'h08, "R3", 2);
      tick(3);
      pa_in = 8'h11;
      tick(1);
      cpu_rd(2'd0, 8'hA5, "R2");
      expect_at(0, 8'h28, 8'h00, "R3", 0);
      tick(1);

      // R3 port B strobe with enable clear, then enable it
      pb_in = 8'h4E;
      drv_c[2] = 1'b0;
      expect_at(0, 8'h02, 8'h02, "R2", 3);
      tick(4);
      drv_c[2] = 1'b1;
      expect_at(0, 8'h03, 8'h02, "R3", 3);
      tick(4);
      cpu_wr(2'd3, 8'h05);
      expect_at(0, 8'h01, 8'h01, "R3", 0);
      tick(1);
      cpu_rd(2'd1, 8'h4E, "R2");
      expect_at(0, 8'h03, 8'h00, "R3", 0);

      // R10 write to input-mode port ignored
      cpu_wr(2'd0, 8'h77);
      cpu_rd(2'd0, 8'hA5, "R10");

      // leave port B full, then switch A to output, B input
      pb_in = 8'h21;
      drv_c[2] = 1'b0;
      tick(4);
      drv_c[2] = 1'b1;
      tick(4);
      expect_at(0, 8'h03, 8'h03, "R3", 0);
      tick(1);
      cpu_wr(2'd3, 8'h82);
      expect_at(0, 8'hFF, 8'h80, "R7", 0);
      expect_at(4, 8'hFF, 8'hBB, "R6", 0);
      expect_at(5, 8'hFF, 8'h02, "R6", 0);
      tick(1);
      cpu_rd(2'd2, 8'h80, "R9");

      // R8 enable A via index 6, R4/R5 output handshake
      cpu_wr(2'd3, 8'h0D);
      cpu_rd(2'd2, 8'hC0, "R8");
      cpu_wr(2'd0, 8'h3C);
      expect_at(1, 8'hFF, 8'h3C, "R4", 0);
      expect_at(0, 8'h88, 8'h00, "R4", 0);
      tick(1);
      drv_c[6] = 1'b0;
      expect_at(0, 8'h80, 8'h00, "R5", 2);
      expect_at(0, 8'h80, 8'h80, "R5", 3);
      tick(4);
      drv_c[6] = 1'b1;
      expect_at(0, 8'h08, 8'h00, "R5", 2);
      expect_at(0, 8'h08, 8'h08, "R5", 3);
      tick(4);
      cpu_wr(2'd0, 8'h5A);
      expect_at(0, 8'h88, 8'h00, "R4", 0);
      expect_at(1, 8'hFF, 8'h5A, "R4", 0);
      tick(1);

      // R8 free pin write and ignored index, R9 status
      cpu_wr(2'd3, 8'h0B);
      expect_at(0, 8'h30, 8'h20, "R8", 0);
      cpu_wr(2'd3, 8'h07);
      expect_at(0, 8'h08, 8'h00, "R8", 0);
      tick(1);
      cpu_rd(2'd2, 8'h60, "R9");

      // R7 reserved mode word ignored
      cpu_wr(2'd3, 8'hC0);
      expect_at(5, 8'hFF, 8'h02, "R7", 0);
      expect_at(0, 8'h20, 8'h20, "R7", 0);
      tick(1);

      // both outputs
      cpu_wr(2'd3, 8'h80);
      expect_at(0, 8'hFF, 8'h82, "R7", 0);
      expect_at(5, 8'hFF, 8'h03, "R6", 0);
      expect_at(4, 8'hFF, 8'hBB, "R6", 0);
      tick(1);
      cpu_wr(2'd1, 8'h99);
      expect_at(2, 8'hFF, 8'h99, "R4", 0);
      expect_at(0, 8'h03, 8'h00, "R4", 0);
      tick(1);
      drv_c[2] = 1'b0;
      expect_at(0, 8'h02, 8'h02, "R5", 3);
      tick(4);
      drv_c[2] = 1'b1;
      expect_at(0, 8'h01, 8'h00, "R5", 3);
      tick(6);

      if (sb.size() != 0) begin
         errors += sb.size();
         checks += sb.size();
         $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule